// File: doc/BRIEF.md
# Interleaved Transfer Address Sequencer

This block generates the source and destination byte addresses for a strided or interleaved copy described by a stored pattern. Software first loads a header and a pattern table. The header holds the two base addresses, the increment and scatter flags for each side, a 2-bit direction code, the repeat count and the number of table entries. Each table entry is a {run length, skip} pair. After a start pulse the block walks the table once per repetition. For every accepted handshake cycle it presents one source/destination address pair together with the direction code, and it pulses `done` once the whole pattern has been issued.

A run is a block of contiguous bytes. After the last byte of a run, a side whose increment and scatter flags are both set jumps forward by that entry's skip value. A side that increments without scatter treats every skip as zero. A side whose increment flag is clear holds its base address for every byte, and its scatter flag is then ignored, which suits a peripheral FIFO. Both sides move through the same number of bytes in the same order.

The controller is a three-state machine: `S_IDLE`, `S_RUN` and `S_FIN`. The transitions are:
- `S_IDLE -> S_RUN` on a start with a non-empty pattern.
- `S_IDLE -> S_FIN` on a start with an empty pattern.
- `S_RUN -> S_RUN` while entries remain. Each pair is offered and advances on a handshake, and each zero-length entry takes one skip cycle.
- `S_RUN -> S_FIN` when the last entry of the last repetition ends.
- `S_FIN -> S_IDLE` unconditionally. `done` is high in `S_FIN`.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, `ap_valid`, `done` and `busy` are low.
- R2: On a side with increment set and scatter clear, consecutive bytes within a run have addresses that differ by +1, starting at the side's base address.
- R3: On a side with increment and scatter both set, the address after the last byte of an entry's run is that byte's address + 1 + the entry's skip value, and each entry uses its own skip.
- R4: On a side with increment set and scatter clear, all skip values are treated as zero, so the side advances by exactly 1 per accepted pair across run boundaries.
- R5: On a side with increment clear, every pair carries the side's base address, whatever its scatter flag.
- R6: The table (entries 0 to `hdr_entries`-1, in index order) is repeated `hdr_frames` times. The skip of the last entry is applied before the first byte of the next repetition.
- R7: A pair is accepted only when `ap_valid` and `ap_ready` are both high. While `ap_ready` is low, `ap_valid` stays high and both addresses hold.
- R8: `ap_dir` carries the 2-bit direction code written to the header (0 memory to memory, 1 memory to device, 2 device to memory, 3 device to device) and holds it unchanged during a transfer.
- R9: While `busy` is high, a start pulse and any header or table write are ignored. The running transfer and the stored pattern are unchanged.
- R10: `done` is high for exactly one cycle, in the cycle after the final pair is accepted. `busy` is low in the following cycle.
- R11: A start with `hdr_frames` = 0, `hdr_entries` = 0, or all used run lengths zero gives a `done` pulse in the cycle after the start and never raises `ap_valid`.
- R12: An entry with run length zero emits no pair, but its skip value is still applied to scattering sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_we | input | 1 | Header write strobe |
| hdr_src_base | input | 32 | Source base byte address |
| hdr_dst_base | input | 32 | Destination base byte address |
| hdr_src_inc | input | 1 | Source address increments |
| hdr_src_scat | input | 1 | Source applies skip values |
| hdr_dst_inc | input | 1 | Destination address increments |
| hdr_dst_scat | input | 1 | Destination applies skip values |
| hdr_dir | input | 2 | Direction code |
| hdr_frames | input | 16 | Pattern repeat count |
| hdr_entries | input | 5 | Number of table entries used (0 to 16) |
| ent_we | input | 1 | Table entry write strobe |
| ent_idx | input | 4 | Table entry index |
| ent_size | input | 16 | Run length in bytes |
| ent_gap | input | 16 | Skip in bytes after the run |
| start | input | 1 | Start pulse |
| ap_ready | input | 1 | Consumer accepts the current pair |
| ap_valid | output | 1 | An address pair is offered |
| ap_src | output | 32 | Source byte address |
| ap_dst | output | 32 | Destination byte address |
| ap_dir | output | 2 | Direction code of the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit run, skip and repeat fields, and a 16-entry table. Its patterns use at most four entries and three repetitions. That is enough to reach every flag combination per side, skips that differ per entry, a zero-length entry in mid-table, all three empty-pattern cases, and a transfer with stalls in which writes and a start are attempted mid-run. The stored pattern is then replayed to show it is unchanged.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIN  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic inc;
        logic scat;
    } side_cfg_t;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_SRC  = 0;
    localparam int SIDE_DST  = 1;

endpackage

// File: rtl/ilv_pattern_table.sv
module ilv_pattern_table
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int ENT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              hdr_we,
    input  logic [ADDR_W-1:0] hdr_src_base,
    input  logic [ADDR_W-1:0] hdr_dst_base,
    input  side_cfg_t         hdr_src_cfg,
    input  side_cfg_t         hdr_dst_cfg,
    input  logic [1:0]        hdr_dir,
    input  logic [CNT_W-1:0]  hdr_frames,
    input  logic [ENT_W-1:0]  hdr_entries,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [LEN_W-1:0]  ent_size,
    input  logic [LEN_W-1:0]  ent_gap,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output side_cfg_t         src_cfg,
    output side_cfg_t         dst_cfg,
    output logic [1:0]        dir,
    output logic [CNT_W-1:0]  frames,
    output logic [ENT_W-1:0]  entries,
    output logic [LEN_W-1:0]  rd_size,
    output logic [LEN_W-1:0]  rd_gap,
    output logic              has_data
);

    logic [LEN_W-1:0] size_q [DEPTH];
    logic [LEN_W-1:0] gap_q  [DEPTH];
    logic [DEPTH-1:0] nz;

    // header registers, frozen while a transfer runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            src_cfg  <= '0;
            dst_cfg  <= '0;
            dir      <= '0;
            frames   <= '0;
            entries  <= '0;
        end else if (hdr_we && !lock) begin
            src_base <= hdr_src_base;
            dst_base <= hdr_dst_base;
            src_cfg  <= hdr_src_cfg;
            dst_cfg  <= hdr_dst_cfg;
            dir      <= hdr_dir;
            frames   <= hdr_frames;
            entries  <= hdr_entries;
        end
    end

    // entry storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                size_q[i] <= '0;
                gap_q[i]  <= '0;
            end
        end else if (ent_we && !lock) begin
            size_q[ent_idx] <= ent_size;
            gap_q[ent_idx]  <= ent_gap;
        end
    end

    assign rd_size = size_q[rd_idx];
    assign rd_gap  = gap_q[rd_idx];

    // does any used entry carry at least one byte
    for (genvar i = 0; i < DEPTH; i++) begin : g_nz
        assign nz[i] = (ENT_W'(i) < entries) && (size_q[i] != '0);
    end

    assign has_data = |nz;

    AST_TABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(frames) && $stable(entries) && $stable(dir)) // R9
        else $error("header changed while locked");

endmodule

// File: rtl/ilv_side_addr.sv
module ilv_side_addr
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  side_cfg_t         cfg,
    input  logic              step,
    input  logic              chunk_end,
    input  logic              skip,
    input  logic [LEN_W-1:0]  gap,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] jump;

    // skip only counts on a scattering side
    assign jump = cfg.scat ? ADDR_W'(gap) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base;
        end else if (cfg.inc) begin
            if (step) begin
                addr_q <= addr_q + ADDR_W'(1) + (chunk_end ? jump : '0);
            end else if (skip) begin
                addr_q <= addr_q + jump;
            end
        end
    end

    assign addr = addr_q;

    AST_FIXED_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        active && !cfg.inc |-> addr_q == base) // R5
        else $error("fixed side moved");

    AST_CONTIG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        active && step && cfg.inc && !cfg.scat |=> addr_q == $past(addr_q) + ADDR_W'(1)) // R4
        else $error("contiguous side did not step by one");

endmodule

// File: rtl/ilv_seq_fsm.sv
module ilv_seq_fsm
    import ilv_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 16,
    parameter int IDX_W = 4,
    parameter int ENT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] frames,
    input  logic [ENT_W-1:0] entries,
    input  logic             has_data,
    input  logic [LEN_W-1:0] cur_size,
    input  logic             ready,
    output logic [IDX_W-1:0] rd_idx,
    output logic             valid,
    output logic             step,
    output logic             chunk_end,
    output logic             skip,
    output logic             load,
    output logic             busy,
    output logic             done
);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] frm_q;
    logic [LEN_W-1:0] boff_q;

    logic zero_ent, run_last, xfer, seg_end, last_ent, last_frm, fin, start_ok;

    assign zero_ent = (cur_size == '0);
    assign run_last = (boff_q == cur_size - LEN_W'(1));
    assign xfer     = (state_q == S_RUN) && !zero_ent && ready;
    assign seg_end  = (state_q == S_RUN) && (zero_ent || (xfer && run_last));
    assign last_ent = (ENT_W'(idx_q) == entries - ENT_W'(1));
    assign last_frm = (frm_q == frames - CNT_W'(1));
    assign fin      = seg_end && last_ent && last_frm;
    assign start_ok = (frames != '0) && (entries != '0) && has_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = start_ok ? S_RUN : S_FIN;
            S_RUN:  if (fin)   state_d = S_FIN;
            S_FIN:             state_d = S_IDLE;
            default:           state_d = S_IDLE;
        endcase
    end

    // position counters: entry index, repetition, byte within run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            frm_q  <= '0;
            boff_q <= '0;
        end else if (state_q == S_IDLE && start) begin
            idx_q  <= '0;
            frm_q  <= '0;
            boff_q <= '0;
        end else if (seg_end) begin
            boff_q <= '0;
            if (last_ent) begin
                idx_q <= '0;
                frm_q <= frm_q + CNT_W'(1);
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end else if (xfer) begin
            boff_q <= boff_q + LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        valid     = 1'b0;
        skip      = 1'b0;
        load      = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            S_RUN: begin
                valid = !zero_ent;
                skip  = zero_ent;
            end
            S_FIN: done = 1'b1;
            default: busy = 1'b0;
        endcase
        step      = xfer;
        chunk_end = xfer && run_last;
    end

    assign rd_idx = idx_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy) // R10
        else $error("done longer than one cycle");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !valid && !done) // R1
        else $error("activity while idle");

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid) // R7
        else $error("offer withdrawn without acceptance");

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) && start && !fin |=> (state_q == S_RUN)) // R9
        else $error("start disturbed a running transfer");

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ENT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_we,
    input  logic [ADDR_W-1:0] hdr_src_base,
    input  logic [ADDR_W-1:0] hdr_dst_base,
    input  logic              hdr_src_inc,
    input  logic              hdr_src_scat,
    input  logic              hdr_dst_inc,
    input  logic              hdr_dst_scat,
    input  logic [1:0]        hdr_dir,
    input  logic [CNT_W-1:0]  hdr_frames,
    input  logic [ENT_W-1:0]  hdr_entries,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [LEN_W-1:0]  ent_size,
    input  logic [LEN_W-1:0]  ent_gap,
    input  logic              start,
    input  logic              ap_ready,
    output logic              ap_valid,
    output logic [ADDR_W-1:0] ap_src,
    output logic [ADDR_W-1:0] ap_dst,
    output logic [1:0]        ap_dir,
    output logic              busy,
    output logic              done
);

    logic [ADDR_W-1:0] base   [NUM_SIDES];
    side_cfg_t         cfg    [NUM_SIDES];
    logic [ADDR_W-1:0] addr   [NUM_SIDES];
    logic [CNT_W-1:0]  frames;
    logic [ENT_W-1:0]  entries;
    logic [IDX_W-1:0]  rd_idx;
    logic [LEN_W-1:0]  rd_size, rd_gap;
    logic              has_data, step, chunk_end, skip, load;

    ilv_pattern_table #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
        .DEPTH(DEPTH), .IDX_W(IDX_W), .ENT_W(ENT_W)
    ) i_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock        (busy),
        .hdr_we      (hdr_we),
        .hdr_src_base(hdr_src_base),
        .hdr_dst_base(hdr_dst_base),
        .hdr_src_cfg ('{inc: hdr_src_inc, scat: hdr_src_scat}),
        .hdr_dst_cfg ('{inc: hdr_dst_inc, scat: hdr_dst_scat}),
        .hdr_dir     (hdr_dir),
        .hdr_frames  (hdr_frames),
        .hdr_entries (hdr_entries),
        .ent_we      (ent_we),
        .ent_idx     (ent_idx),
        .ent_size    (ent_size),
        .ent_gap     (ent_gap),
        .rd_idx      (rd_idx),
        .src_base    (base[SIDE_SRC]),
        .dst_base    (base[SIDE_DST]),
        .src_cfg     (cfg[SIDE_SRC]),
        .dst_cfg     (cfg[SIDE_DST]),
        .dir         (ap_dir),
        .frames      (frames),
        .entries     (entries),
        .rd_size     (rd_size),
        .rd_gap      (rd_gap),
        .has_data    (has_data)
    );

    ilv_seq_fsm #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .ENT_W(ENT_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frames   (frames),
        .entries  (entries),
        .has_data (has_data),
        .cur_size (rd_size),
        .ready    (ap_ready),
        .rd_idx   (rd_idx),
        .valid    (ap_valid),
        .step     (step),
        .chunk_end(chunk_end),
        .skip     (skip),
        .load     (load),
        .busy     (busy),
        .done     (done)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        ilv_side_addr #(
            .ADDR_W(ADDR_W), .LEN_W(LEN_W)
        ) i_side (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (busy),
            .load     (load),
            .base     (base[s]),
            .cfg      (cfg[s]),
            .step     (step),
            .chunk_end(chunk_end),
            .skip     (skip),
            .gap      (rd_gap),
            .addr     (addr[s])
        );
    end

    assign ap_src = addr[SIDE_SRC];
    assign ap_dst = addr[SIDE_DST];

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid && !ap_ready |=> $stable(ap_src) && $stable(ap_dst)) // R7
        else $error("pair changed while stalled");

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(ap_dir)) // R8
        else $error("direction changed during transfer");

endmodule

// File: tb/test_ilv_addr_gen.sv
module test_ilv_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_we = 1'b0;
    logic [31:0] hdr_src_base = '0, hdr_dst_base = '0;
    logic        hdr_src_inc = 1'b0, hdr_src_scat = 1'b0;
    logic        hdr_dst_inc = 1'b0, hdr_dst_scat = 1'b0;
    logic [1:0]  hdr_dir = '0;
    logic [15:0] hdr_frames = '0;
    logic [4:0]  hdr_entries = '0;
    logic        ent_we = 1'b0;
    logic [3:0]  ent_idx = '0;
    logic [15:0] ent_size = '0, ent_gap = '0;
    logic        start = 1'b0;
    logic        ap_ready = 1'b0;
    logic        ap_valid;
    logic [31:0] ap_src, ap_dst;
    logic [1:0]  ap_dir;
    logic        busy, done;

    int tests = 0;
    int fails = 0;

    // reference template
    logic [31:0] m_sb, m_db;
    bit          m_si, m_ss, m_di, m_ds;
    logic [1:0]  m_dir;
    int          m_frames, m_n;
    int          m_size [16];
    int          m_gap  [16];
    logic [31:0] q_src [$];
    logic [31:0] q_dst [$];

    always #4 clk = ~clk;

    ilv_addr_gen i_ilv_addr_gen (
        .clk(clk), .rst_n(rst_n), .hdr_we(hdr_we),
        .hdr_src_base(hdr_src_base), .hdr_dst_base(hdr_dst_base),
        .hdr_src_inc(hdr_src_inc), .hdr_src_scat(hdr_src_scat),
        .hdr_dst_inc(hdr_dst_inc), .hdr_dst_scat(hdr_dst_scat),
        .hdr_dir(hdr_dir), .hdr_frames(hdr_frames), .hdr_entries(hdr_entries),
        .ent_we(ent_we), .ent_idx(ent_idx), .ent_size(ent_size), .ent_gap(ent_gap),
        .start(start), .ap_ready(ap_ready), .ap_valid(ap_valid),
        .ap_src(ap_src), .ap_dst(ap_dst), .ap_dir(ap_dir),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_hdr(input logic [31:0] sb, input logic [31:0] db,
                           input bit si, input bit ss, input bit di, input bit ds,
                           input logic [1:0] dr, input int fr, input int n);
        m_sb = sb; m_db = db; m_si = si; m_ss = ss; m_di = di; m_ds = ds;
        m_dir = dr; m_frames = fr; m_n = n;
        hdr_src_base = sb; hdr_dst_base = db;
        hdr_src_inc = si; hdr_src_scat = ss; hdr_dst_inc = di; hdr_dst_scat = ds;
        hdr_dir = dr; hdr_frames = 16'(fr); hdr_entries = 5'(n);
        hdr_we = 1'b1;
        @(negedge clk);
        hdr_we = 1'b0;
    endtask

    task automatic set_ent(input int i, input int sz, input int gp);
        m_size[i] = sz; m_gap[i] = gp;
        ent_idx = 4'(i); ent_size = 16'(sz); ent_gap = 16'(gp);
        ent_we = 1'b1;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    // behavioural expectation of the full pair stream
    task automatic build_model();
        logic [31:0] s, d;
        q_src.delete();
        q_dst.delete();
        s = m_sb;
        d = m_db;
        for (int f = 0; f < m_frames; f++) begin
            for (int e = 0; e < m_n; e++) begin
                for (int b = 0; b < m_size[e]; b++) begin
                    q_src.push_back(s);
                    q_dst.push_back(d);
                    if (m_si) s = s + 32'd1;
                    if (m_di) d = d + 32'd1;
                end
                if (m_si && m_ss) s = s + 32'(m_gap[e]);
                if (m_di && m_ds) d = d + 32'(m_gap[e]);
            end
        end
    endtask

    task automatic run_xfer(input string req, input int rmode, input bit poke);
        int  cyc;
        bit  pend;
        bit  fin;
        build_model();
        pend = 0;
        fin  = 0;
        cyc  = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            ap_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
            if (poke && cyc == 3) begin
                start = 1'b1; hdr_we = 1'b1; hdr_frames = 16'd9; hdr_dir = ~m_dir;
                ent_we = 1'b1; ent_idx = 4'd0; ent_size = 16'd11; ent_gap = 16'd5;
            end else if (poke && cyc == 4) begin
                start = 1'b0; hdr_we = 1'b0; ent_we = 1'b0;
            end
            #1;
            if (pend) begin
                chk(done === 1'b1, "R10", "done one cycle after final pair", longint'(done), 1);
                fin = 1;
            end else if (done) begin
                chk(q_src.size() == 0, req, "done before all pairs", q_src.size(), 0);
                fin = 1;
            end else if (ap_valid) begin
                if (q_src.size() == 0) begin
                    chk(1'b0, req, "valid with no pair expected", 1, 0);
                    fin = 1;
                end else begin
                    chk(ap_src == q_src[0], req, "source address", ap_src, q_src[0]);
                    chk(ap_dst == q_dst[0], req, "destination address", ap_dst, q_dst[0]);
                    chk(ap_dir == m_dir, req, "direction", ap_dir, m_dir);
                    if (ap_ready) begin
                        void'(q_src.pop_front());
                        void'(q_dst.pop_front());
                        if (q_src.size() == 0) pend = 1;
                    end
                end
            end
            cyc++;
            if (cyc > 3000) begin
                chk(1'b0, req, "transfer timeout", cyc, 0);
                fin = 1;
            end
            if (!fin) @(negedge clk);
        end
        @(negedge clk);
        #1;
        chk(!done && !busy, "R10", "done pulse ends and idle", {done, busy}, 0);
        ap_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_size[i] = 0;
            m_gap[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(!ap_valid && !done && !busy, "R1", "outputs in reset", {ap_valid, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!ap_valid && !done && !busy, "R1", "outputs after reset", {ap_valid, done, busy}, 0);

        // R2: both sides contiguous, single run
        set_ent(0, 5, 3);
        set_hdr(32'h1000, 32'h8000, 1, 0, 1, 0, 2'd0, 1, 1);
        run_xfer("R2", 0, 0);

        // R3: both sides scatter, per-entry skips
        set_ent(0, 3, 4);
        set_ent(1, 1, 0);
        set_ent(2, 2, 7);
        set_hdr(32'h2000, 32'h3000, 1, 1, 1, 1, 2'd0, 1, 3);
        run_xfer("R3", 0, 0);

        // R6: same table repeated, last skip applied between repetitions
        set_hdr(32'h2000, 32'h3000, 1, 1, 1, 1, 2'd0, 3, 3);
        run_xfer("R6", 0, 0);

        // R4: source scatters, destination contiguous, with stalls
        set_hdr(32'h4000, 32'h5000, 1, 1, 1, 0, 2'd0, 2, 3);
        run_xfer("R4", 1, 0);

        // R7: stalls on a two-entry pattern
        set_ent(0, 4, 2);
        set_ent(1, 2, 9);
        set_hdr(32'h0000_0ff0, 32'hffff_fff8, 1, 1, 1, 1, 2'd0, 2, 2);
        run_xfer("R7", 1, 0);

        // R5: fixed source (scatter flag set but ignored), scattering destination
        set_hdr(32'h9000_0040, 32'h6000, 0, 1, 1, 1, 2'd2, 2, 2);
        run_xfer("R5", 0, 0);

        // R8: device to device, both fixed; memory to device
        set_hdr(32'hA000_0000, 32'hB000_0000, 0, 0, 0, 0, 2'd3, 1, 2);
        run_xfer("R8", 1, 0);
        set_hdr(32'h7000, 32'hC000_0010, 1, 1, 0, 0, 2'd1, 1, 2);
        run_xfer("R8", 0, 0);

        // R12: zero-length entry in mid-table keeps its skip
        set_ent(0, 2, 1);
        set_ent(1, 0, 5);
        set_ent(2, 3, 2);
        set_hdr(32'h100, 32'h200, 1, 1, 1, 1, 2'd0, 2, 3);
        run_xfer("R12", 0, 0);

        // R11: empty patterns
        set_hdr(32'h100, 32'h200, 1, 1, 1, 1, 2'd0, 0, 3);
        run_xfer("R11", 0, 0);
        set_hdr(32'h100, 32'h200, 1, 1, 1, 1, 2'd0, 2, 0);
        run_xfer("R11", 0, 0);
        set_ent(0, 0, 3);
        set_ent(1, 0, 4);
        set_hdr(32'h100, 32'h200, 1, 1, 1, 1, 2'd0, 2, 2);
        run_xfer("R11", 0, 0);

        // R9: start and writes mid-transfer are ignored, then pattern replays unchanged
        set_ent(0, 4, 3);
        set_ent(1, 3, 1);
        set_hdr(32'h4400, 32'h5500, 1, 1, 1, 1, 2'd1, 2, 2);
        run_xfer("R9", 1, 1);
        run_xfer("R9", 0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule